// File: doc/BRIEF.md
# Pipeline Bypass and Load Interlock Controller

This block is the hazard control for a five-stage in-order integer pipeline. It compares the source register indices of the instructions in the decode and execute stages against the destination indices, write flags and load flags held in the three downstream pipeline registers. From these comparisons it chooses where each ALU operand comes from, whether the store data of the instruction in the memory stage is replaced by the value being written back, and whether the front of the pipeline must hold for one cycle while a no-op is put into execute.

Every decision is combinational and valid in the same cycle as its inputs. The clock and reset only qualify the built-in assertions. A register file that writes early in a cycle and reads late is assumed, so a producer three instructions ahead is not bypassed here. The pipeline registers, ALU and memories are outside the block.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With no index match on any downstream write, both ALU operand selects are 00 (register file), the store data select is 0 and the three stall outputs are 0.
- R2: When the execute-stage source equals the EXE/MEM destination, that entry writes, is not a load and the index is nonzero, the operand select is 10.
- R3: When only the MEM/WB entry writes a nonzero destination equal to the execute-stage source, the operand select is 01.
- R4: When both EXE/MEM and MEM/WB qualify for the same source, the select is 10, the newer value.
- R5: Register 0 and entries whose write flag is clear never cause forwarding, store bypass or a stall.
- R6: A load held in EXE/MEM is never forwarded from there; the source then falls back to MEM/WB (01) if it matches, else 00.
- R7: When ID/EXE holds a writing load with a nonzero destination that matches a source the decode instruction reads, pc_hold, ifid_hold and idex_bubble are all 1 in that cycle.
- R8: A match on a source that the decode instruction flags as unread causes no stall.
- R9: For a store in decode, a load match on its data source (second source) alone causes no stall; a match on its address source (first source) does.
- R10: st_data_sel is 1 exactly when EXE/MEM holds a store whose data source is nonzero and equals a MEM/WB destination with its write flag set.
- R11: The second ALU operand select is decided from the second execute source by the same rules, independently of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for assertion sampling |
| rst_n | input | 1 | Active-low reset, disables assertions |
| id_src_a | input | REG_W | First source index of the decode instruction |
| id_src_b | input | REG_W | Second source index of the decode instruction |
| id_reads_a | input | 1 | Decode instruction reads its first source |
| id_reads_b | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (second source is data) |
| ex_src_a | input | REG_W | First source of the instruction in execute |
| ex_src_b | input | REG_W | Second source of the instruction in execute |
| ex_dst | input | REG_W | ID/EXE destination index |
| ex_wr | input | 1 | ID/EXE write flag |
| ex_is_load | input | 1 | ID/EXE holds a load |
| mem_dst | input | REG_W | EXE/MEM destination index |
| mem_wr | input | 1 | EXE/MEM write flag |
| mem_is_load | input | 1 | EXE/MEM holds a load |
| mem_is_store | input | 1 | EXE/MEM holds a store |
| mem_data_src | input | REG_W | Data source index of the store in EXE/MEM |
| wb_dst | input | REG_W | MEM/WB destination index |
| wb_wr | input | 1 | MEM/WB write flag |
| alu_a_sel | output | 2 | First ALU operand source: 00 file, 01 MEM/WB, 10 EXE/MEM |
| alu_b_sel | output | 2 | Second ALU operand source, same coding |
| st_data_sel | output | 1 | 1 replaces store data with the MEM/WB value |
| pc_hold | output | 1 | Keep the PC |
| ifid_hold | output | 1 | Keep the IF/ID register |
| idex_bubble | output | 1 | Load a no-op into ID/EXE |

## Verification
The bench sweeps every combination of a small index space, so it hits the double match where a design preferring the older write would hand the ALU a stale value, the load sitting in EXE/MEM that a careless forwarder would pass on before its data exists, and register 0 or a cleared write flag that would otherwise make spurious bypasses. The interlock sweep covers unread sources and store data matches, where an over-eager detector stalls needlessly, and address matches on stores, where a lax one lets a wrong address through. The store sweep checks that the memory-copy bypass fires only on a real write to the stored register.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_EXM = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/opnd_bypass.sv
module opnd_bypass #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             exm_wr,
    input  logic             exm_ld,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output hz_pkg::opnd_src_e sel
);
    logic live_src;
    logic exm_hit;
    logic wb_hit;

    always_comb begin
        live_src = (src != '0);
        exm_hit  = live_src && exm_wr && !exm_ld && (exm_dst == src);
        wb_hit   = live_src && wb_wr && (wb_dst == src);
        if (exm_hit)
            sel = hz_pkg::SRC_EXM;
        else if (wb_hit)
            sel = hz_pkg::SRC_WB;
        else
            sel = hz_pkg::SRC_RF;
    end
endmodule

// File: rtl/load_use_guard.sv
module load_use_guard #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] dst,
    input  logic             wr,
    input  logic             is_load,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             reads_a,
    input  logic             reads_b,
    input  logic             is_store,
    output logic             stall
);
    logic live_load;
    logic hit_a;
    logic hit_b;

    always_comb begin
        live_load = is_load && wr && (dst != '0);
        hit_a     = reads_a && (src_a == dst);
        hit_b     = reads_b && !is_store && (src_b == dst);
        stall     = live_load && (hit_a || hit_b);
    end
endmodule

// File: rtl/store_bypass.sv
module store_bypass #(
    parameter int REG_W = 5
) (
    input  logic             is_store,
    input  logic [REG_W-1:0] data_src,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic             take_wb
);
    always_comb begin
        take_wb = is_store && wb_wr && (data_src != '0) && (wb_dst == data_src);
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_reads_a,
    input  logic             id_reads_b,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             mem_is_load,
    input  logic             mem_is_store,
    input  logic [REG_W-1:0] mem_data_src,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic [1:0]       alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic             st_data_sel,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);
    localparam int NUM_OPS = 2;

    logic [REG_W-1:0]  ex_src [NUM_OPS];
    hz_pkg::opnd_src_e op_sel [NUM_OPS];
    logic              lu_stall;

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_opnd
        opnd_bypass #(.REG_W(REG_W)) u_byp (
            .src     (ex_src[g]),
            .exm_dst (mem_dst),
            .exm_wr  (mem_wr),
            .exm_ld  (mem_is_load),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .sel     (op_sel[g])
        );
    end

    assign alu_a_sel = op_sel[0];
    assign alu_b_sel = op_sel[1];

    load_use_guard #(.REG_W(REG_W)) u_lu (
        .dst      (ex_dst),
        .wr       (ex_wr),
        .is_load  (ex_is_load),
        .src_a    (id_src_a),
        .src_b    (id_src_b),
        .reads_a  (id_reads_a),
        .reads_b  (id_reads_b),
        .is_store (id_is_store),
        .stall    (lu_stall)
    );

    assign pc_hold     = lu_stall;
    assign ifid_hold   = lu_stall;
    assign idex_bubble = lu_stall;

    store_bypass #(.REG_W(REG_W)) u_stb (
        .is_store (mem_is_store),
        .data_src (mem_data_src),
        .wb_dst   (wb_dst),
        .wb_wr    (wb_wr),
        .take_wb  (st_data_sel)
    );

    // R4
    newest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a != '0 && mem_wr && !mem_is_load && mem_dst == ex_src_a
         && wb_wr && wb_dst == ex_src_a) |-> alu_a_sel == 2'b10);

    // R6
    no_load_exm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_is_load |-> (alu_a_sel != 2'b10 && alu_b_sel != 2'b10));

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a == '0) |-> (alu_a_sel == 2'b00));

    // R7
    stall_bundle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

    // R7
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_is_load && ex_wr && ex_dst != '0));

    // R10
    st_sel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_data_sel |-> (mem_is_store && wb_wr && wb_dst == mem_data_src));

    // R11
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_a_sel != 2'b11) && (alu_b_sel != 2'b11));
endmodule

// File: tb/pipe_hazard_ctl_bench.sv
module pipe_hazard_ctl_bench;
    localparam int RW = 2;
    localparam int NR = 1 << RW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [RW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, mem_data_src, wb_dst;
    logic id_reads_a, id_reads_b, id_is_store, ex_wr, ex_is_load;
    logic mem_wr, mem_is_load, mem_is_store, wb_wr;
    logic [1:0] alu_a_sel, alu_b_sel;
    logic st_data_sel, pc_hold, ifid_hold, idex_bubble;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pipe_hazard_ctl #(.REG_W(RW)) u_pipe_hazard_ctl (
        .clk(clk), .rst_n(rst_n),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_reads_a(id_reads_a), .id_reads_b(id_reads_b), .id_is_store(id_is_store),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
        .ex_wr(ex_wr), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_is_load(mem_is_load),
        .mem_is_store(mem_is_store), .mem_data_src(mem_data_src),
        .wb_dst(wb_dst), .wb_wr(wb_wr),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .st_data_sel(st_data_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        id_src_a = '0; id_src_b = '0; id_reads_a = 0; id_reads_b = 0; id_is_store = 0;
        ex_src_a = '0; ex_src_b = '0; ex_dst = '0; ex_wr = 0; ex_is_load = 0;
        mem_dst = '0; mem_wr = 0; mem_is_load = 0; mem_is_store = 0; mem_data_src = '0;
        wb_dst = '0; wb_wr = 0;
    endtask

    function automatic int exp_sel(int s, int md, int mw, int ml, int wd, int ww);
        if (s != 0 && mw != 0 && ml == 0 && md == s) return 2;
        if (s != 0 && ww != 0 && wd == s) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int s, int md, int mw, int ml, int wd, int ww);
        bit mhit, whit;
        mhit = (s != 0 && mw != 0 && ml == 0 && md == s);
        whit = (s != 0 && ww != 0 && wd == s);
        if (s == 0) return "R5";
        if (mhit && whit) return "R4";
        if (mhit) return "R2";
        if (mw != 0 && ml != 0 && md == s) return "R6";
        if (whit) return "R3";
        if (md == s || wd == s) return "R5";
        return "R1";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        #5;
        // R1 outputs idle under reset with no matches
        check("R1 a_sel", int'(alu_a_sel), 0);
        check("R1 b_sel", int'(alu_b_sel), 0);
        check("R1 stall", int'(pc_hold | ifid_hold | idex_bubble), 0);
        check("R1 st_sel", int'(st_data_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Operand bypass sweep: R1 to R6 on operand a, R11 on operand b
        for (int s = 0; s < NR; s++)
        for (int md = 0; md < NR; md++)
        for (int mw = 0; mw < 2; mw++)
        for (int ml = 0; ml < 2; ml++)
        for (int wd = 0; wd < NR; wd++)
        for (int ww = 0; ww < 2; ww++) begin
            int sb;
            sb = (s + 1) % NR;
            @(negedge clk);
            clear_all();
            ex_src_a = RW'(s); ex_src_b = RW'(sb);
            mem_dst = RW'(md); mem_wr = mw[0]; mem_is_load = ml[0];
            wb_dst = RW'(wd); wb_wr = ww[0];
            #5;
            check(sel_tag(s, md, mw, ml, wd, ww), int'(alu_a_sel), exp_sel(s, md, mw, ml, wd, ww));
            check("R11", int'(alu_b_sel), exp_sel(sb, md, mw, ml, wd, ww));
        end

        // Load-use interlock sweep: R7, R8, R9
        for (int d = 0; d < NR; d++)
        for (int ld = 0; ld < 2; ld++)
        for (int w = 0; w < 2; w++)
        for (int ra = 0; ra < NR; ra++)
        for (int rb = 0; rb < NR; rb++)
        for (int ua = 0; ua < 2; ua++)
        for (int ub = 0; ub < 2; ub++)
        for (int st = 0; st < 2; st++) begin
            bit live, ha, hb, stl;
            string tg;
            live = (ld != 0 && w != 0 && d != 0);
            ha = (ua != 0 && ra == d);
            hb = (ub != 0 && rb == d && st == 0);
            stl = live && (ha || hb);
            if (stl) tg = "R7";
            else if (live && st != 0 && ub != 0 && rb == d) tg = "R9";
            else if (live && ((ua == 0 && ra == d) || (ub == 0 && rb == d))) tg = "R8";
            else if (d == 0 || w == 0) tg = "R5";
            else tg = "R1";
            @(negedge clk);
            clear_all();
            ex_dst = RW'(d); ex_is_load = ld[0]; ex_wr = w[0];
            id_src_a = RW'(ra); id_src_b = RW'(rb);
            id_reads_a = ua[0]; id_reads_b = ub[0]; id_is_store = st[0];
            #5;
            check({tg, " pc_hold"}, int'(pc_hold), int'(stl));
            check({tg, " ifid_hold"}, int'(ifid_hold), int'(stl));
            check({tg, " idex_bubble"}, int'(idex_bubble), int'(stl));
        end

        // Store data bypass sweep: R10
        for (int ms = 0; ms < 2; ms++)
        for (int ds = 0; ds < NR; ds++)
        for (int wd = 0; wd < NR; wd++)
        for (int ww = 0; ww < 2; ww++) begin
            int e;
            e = (ms != 0 && ww != 0 && ds != 0 && wd == ds) ? 1 : 0;
            @(negedge clk);
            clear_all();
            mem_is_store = ms[0]; mem_data_src = RW'(ds);
            wb_dst = RW'(wd); wb_wr = ww[0];
            #5;
            check("R10", int'(st_data_sel), e);
        end

        @(negedge clk);
        finish_run();
    end
endmodule